// File: doc/BRIEF.md
# Pulse-Density Acceleration Sampler

This block turns the pulse-density bitstream of a sigma-delta accelerometer into a stream of signed acceleration samples. It runs on the same reference clock that drives the sensor. In every reference cycle it registers the sensor's count level, and each high level adds one to a free-running accumulator that wraps on overflow. A programmable interval timer marks the end of each sample window. At that point the accumulator is captured and the previous capture is subtracted modulo the counter width. A zero-g offset is then removed, and the signed result appears on the output with a one-cycle valid strobe.

Over one window the raw difference runs from zero at negative full scale to the window length at positive full scale. Zero acceleration sits near half of that range. The offset can be written by software. It can also be learned from the next complete window after a calibration request, for example while the sensor is held at rest. A longer window gives finer quantization and a lower bandwidth, so the window length is an input that can change at run time.

Top module: `pdm_accel_sampler`

## Requirements
- R1: A synchronous reset drives sample_vld_o to 0 and sample_o to 0, and clears the accumulator and the previous capture.
- R2: Each reference cycle whose count level is high, as seen at a rising clock edge, adds exactly one to the accumulator. The raw difference for a window of N cycles equals the number of high levels in N consecutive cycles, from 0 to N.
- R3: sample_o equals the raw difference minus the zero-g offset, as a two's-complement value of CW+1 bits. It is negative when the difference is below the offset.
- R4: The accumulator wraps modulo 2^CW, and the difference is taken modulo 2^CW. Samples therefore stay correct across a counter overflow.
- R5: interval_i sets the window length N in reference cycles, and sample_vld_o pulses once every N cycles. When interval_i is 0 the timer is held idle and no sample is produced.
- R6: The window that ends first after reset produces no sample, so the first strobe comes no earlier than N+1 cycles after reset is released.
- R7: sample_o holds its value between strobes.
- R8: A pulse on zero_wr_i loads zero_data_i as the zero-g offset. The new offset is used for every later sample, and it takes priority over a calibration capture in the same cycle.
- R9: A pulse on cal_req_i stores the raw difference of the next completed window as the new offset. The sample for that window still uses the old offset, and the samples after it use the new one.
- R10: The parameter COUNT_SRC chooses which input is counted. SRC_PULSE (0) counts the return-to-zero count pulse and SRC_DIR (1) counts the direction level. In every cycle the two inputs must agree.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, shared with the sensor |
| rst | input | 1 | Synchronous reset, active high |
| cnt_pulse_i | input | 1 | Return-to-zero count pulse from the sensor |
| dir_level_i | input | 1 | Direction level, high in cycles that carry a pulse |
| interval_i | input | 16 | Window length in reference cycles; 0 = idle |
| zero_wr_i | input | 1 | Load strobe for the zero-g offset |
| zero_data_i | input | CW | Zero-g offset value for a software load |
| cal_req_i | input | 1 | Request to learn the offset from the next window |
| sample_o | output | CW+1 | Signed acceleration count |
| sample_vld_o | output | 1 | One-cycle strobe marking a new sample |

## Verification
The hardest case to reach is a window in which the accumulator overflows. This needs more than 2^CW counted pulses since reset, so the stimulus holds the count line high for 24 windows of 3000 cycles, which passes 65536, and it checks every clean sample in that run. The bench must also place stimulus changes away from window edges without reading the timer. To do this it waits for the first strobe after reset and then shifts by half a window. After that, every pattern change and calibration pulse lands mid-window. Only the one window that straddles each change is marked as don't-care, and the calibrating window and the window after it are predicted exactly.

// File: rtl/pdm_sampler_pkg.sv
package pdm_sampler_pkg;
   localparam int unsigned IVL_W = 16;
   typedef enum logic {
      SRC_PULSE = 1'b0,
      SRC_DIR   = 1'b1
   } cnt_src_e;
endpackage

// File: rtl/pdm_level_capture.sv
module pdm_level_capture
   import pdm_sampler_pkg::*;
#(
   parameter cnt_src_e SRC = SRC_PULSE
) (
   input  logic clk,
   input  logic rst,
   input  logic pulse_i,
   input  logic dir_i,
   output logic hit_o
);
   logic pulse_q, dir_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         pulse_q <= 1'b0;
         dir_q   <= 1'b0;
      end else begin
         pulse_q <= pulse_i;
         dir_q   <= dir_i;
      end
   end

   generate
      if (SRC == SRC_DIR) begin : g_dir
         assign hit_o = dir_q;
      end else begin : g_pulse
         assign hit_o = pulse_q;
      end
   endgenerate

   // R10
   pulse_dir_agree_chk: assert property (@(posedge clk) disable iff (rst)
      pulse_q == dir_q)
      else $error("count pulse and direction level disagree");
endmodule

// File: rtl/pdm_pulse_accum.sv
module pdm_pulse_accum #(
   parameter int unsigned CW = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          hit_i,
   output logic [CW-1:0] acc_o
);
   logic [CW-1:0] acc_q;

   always_ff @(posedge clk) begin
      if (rst)        acc_q <= '0;
      else if (hit_i) acc_q <= acc_q + CW'(1);
   end

   assign acc_o = acc_q;

   // R2 / R4: modular step of zero or one per cycle
   acc_step_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> ((acc_q - $past(acc_q)) == CW'($past(hit_i))))
      else $error("accumulator step wrong");
endmodule

// File: rtl/pdm_interval_timer.sv
module pdm_interval_timer
   import pdm_sampler_pkg::*;
(
   input  logic             clk,
   input  logic             rst,
   input  logic [IVL_W-1:0] interval_i,
   output logic             tick_o
);
   logic [IVL_W-1:0] cnt_q;
   logic             active;

   assign active = (interval_i != '0);
   assign tick_o = active && (cnt_q >= interval_i - IVL_W'(1));

   always_ff @(posedge clk) begin
      if (rst || !active) cnt_q <= '0;
      else if (tick_o)    cnt_q <= '0;
      else                cnt_q <= cnt_q + IVL_W'(1);
   end

   // R5
   idle_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
      (interval_i == '0) |-> !tick_o)
      else $error("tick while idle");

   // R5
   cnt_in_window_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && active && $past(interval_i) == interval_i) |-> (cnt_q < interval_i))
      else $error("timer outside window");
endmodule

// File: rtl/pdm_delta_offset.sv
module pdm_delta_offset #(
   parameter int unsigned CW = 16,
   localparam int unsigned SW = CW + 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          tick_i,
   input  logic          hit_i,
   input  logic [CW-1:0] acc_i,
   input  logic          zero_wr_i,
   input  logic [CW-1:0] zero_data_i,
   input  logic          cal_req_i,
   output logic [SW-1:0] sample_o,
   output logic          sample_vld_o
);
   logic [CW-1:0] prev_q, zero_q, snap, delta;
   logic          have_prev_q, cal_pend_q, vld_q;
   logic [SW-1:0] sample_q;

   assign snap  = acc_i + CW'(hit_i);
   assign delta = snap - prev_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_q      <= '0;
         zero_q      <= '0;
         have_prev_q <= 1'b0;
         cal_pend_q  <= 1'b0;
         vld_q       <= 1'b0;
         sample_q    <= '0;
      end else begin
         vld_q <= 1'b0;
         if (tick_i) begin
            prev_q      <= snap;
            have_prev_q <= 1'b1;
            if (have_prev_q) begin
               sample_q <= $signed({1'b0, delta}) - $signed({1'b0, zero_q});
               vld_q    <= 1'b1;
               if (cal_pend_q) begin
                  zero_q     <= delta;
                  cal_pend_q <= 1'b0;
               end
            end
         end
         if (cal_req_i) cal_pend_q <= 1'b1;
         if (zero_wr_i) zero_q     <= zero_data_i;
      end
   end

   assign sample_o     = sample_q;
   assign sample_vld_o = vld_q;

   // R6
   first_window_silent_chk: assert property (@(posedge clk) disable iff (rst)
      vld_q |-> $past(have_prev_q))
      else $error("sample from first window");

   // R5
   vld_follows_tick_chk: assert property (@(posedge clk) disable iff (rst)
      vld_q |-> $past(tick_i))
      else $error("strobe without window end");

   // R7
   sample_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !vld_q) |-> $stable(sample_q))
      else $error("sample changed without strobe");
endmodule

// File: rtl/pdm_accel_sampler.sv
module pdm_accel_sampler
   import pdm_sampler_pkg::*;
#(
   parameter int unsigned CW        = 16,
   parameter cnt_src_e    COUNT_SRC = SRC_PULSE,
   localparam int unsigned SW       = CW + 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cnt_pulse_i,
   input  logic             dir_level_i,
   input  logic [IVL_W-1:0] interval_i,
   input  logic             zero_wr_i,
   input  logic [CW-1:0]    zero_data_i,
   input  logic             cal_req_i,
   output logic [SW-1:0]    sample_o,
   output logic             sample_vld_o
);
   generate
      if (CW < IVL_W) begin : g_cw_too_small
         $error("CW must be at least the interval width");
      end
   endgenerate

   logic          hit, tick;
   logic [CW-1:0] acc;

   pdm_level_capture #(.SRC(COUNT_SRC)) u_cap (
      .clk(clk), .rst(rst), .pulse_i(cnt_pulse_i), .dir_i(dir_level_i), .hit_o(hit)
   );

   pdm_pulse_accum #(.CW(CW)) u_acc (
      .clk(clk), .rst(rst), .hit_i(hit), .acc_o(acc)
   );

   pdm_interval_timer u_tmr (
      .clk(clk), .rst(rst), .interval_i(interval_i), .tick_o(tick)
   );

   pdm_delta_offset #(.CW(CW)) u_dlt (
      .clk(clk), .rst(rst), .tick_i(tick), .hit_i(hit), .acc_i(acc),
      .zero_wr_i(zero_wr_i), .zero_data_i(zero_data_i), .cal_req_i(cal_req_i),
      .sample_o(sample_o), .sample_vld_o(sample_vld_o)
   );

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      $past(rst) |-> (!sample_vld_o && sample_o == '0))
      else $error("outputs not cleared by reset");
endmodule

// File: tb/pdm_accel_sampler_tb.sv
module pdm_accel_sampler_tb;
   localparam int CW = 16;
   localparam int N  = 3000;
   localparam int WATCHDOG = 190000;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          cnt_pulse_i = 1'b0, dir_level_i = 1'b0;
   logic [15:0]   interval_i = 16'(N);
   logic          zero_wr_i = 1'b0, cal_req_i = 1'b0;
   logic [CW-1:0] zero_data_i = '0;
   logic [CW:0]   sample_o;
   logic          sample_vld_o;

   always #2 clk = ~clk;

   pdm_accel_sampler #(.CW(CW)) u_dut (
      .clk(clk), .rst(rst), .cnt_pulse_i(cnt_pulse_i), .dir_level_i(dir_level_i),
      .interval_i(interval_i), .zero_wr_i(zero_wr_i), .zero_data_i(zero_data_i),
      .cal_req_i(cal_req_i), .sample_o(sample_o), .sample_vld_o(sample_vld_o)
   );

   int tests = 0, fails = 0, cyc = 0;
   int exp_q[$];
   bit dc_q[$];
   string req_q[$];
   bit mon_en = 0, gap_en = 0, hold_en = 0, done = 0;
   int last_vld = -1, gap_err = 0, hold_err = 0, vld_cnt = 0;
   logic [CW:0] last_sample = '0;
   int cur_zero = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic push(input bit dc, input int v, input string req);
      dc_q.push_back(dc); exp_q.push_back(v); req_q.push_back(req);
   endtask

   // monitor: pops expected items as samples appear
   always @(negedge clk) begin
      if (sample_vld_o) vld_cnt++;
      if (hold_en && !sample_vld_o && sample_o != last_sample) hold_err++;
      last_sample = sample_o;
      if (mon_en && sample_vld_o) begin
         if (gap_en && last_vld >= 0 && (cyc - last_vld) != N) gap_err++;
         last_vld = cyc;
         if (exp_q.size() != 0) begin
            automatic bit dc = dc_q.pop_front();
            automatic int e = exp_q.pop_front();
            automatic string r = req_q.pop_front();
            if (!dc) check(r, int'($signed(sample_o)), e);
         end
      end
   end

   // driver: one phase of k windows with m highs per p cycles
   task automatic run_phase(input int m, input int p, input int k, input bit cal,
                            input bit wz, input int zval, input string req);
      int cnt;
      cnt = (N * m) / p;
      push(1'b1, 0, req);
      for (int j = 1; j < k; j++) begin
         if (wz) push(1'b0, cnt - zval, req);
         else if (cal && j == 1) push(1'b0, cnt - cur_zero, req);
         else if (cal) push(1'b0, 0, req);
         else push(1'b0, cnt - cur_zero, req);
      end
      for (int c = 0; c < k * N; c++) begin
         cnt_pulse_i = ((c % p) < m);
         dir_level_i = cnt_pulse_i;
         cal_req_i   = cal && (c == N);
         zero_wr_i   = wz && (c == 0);
         zero_data_i = CW'(zval);
         @(negedge clk);
      end
      cal_req_i = 1'b0; zero_wr_i = 1'b0;
      if (cal) cur_zero = cnt;
      if (wz) cur_zero = zval;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   initial begin
      while (cyc < WATCHDOG) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog: got %0d cycles expected below %0d", cyc, WATCHDOG);
      finish_run();
   end

   initial begin
      int t0;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 vld", int'(sample_vld_o), 0);
      check("R1 sample", int'(sample_o), 0);
      rst = 1'b0;
      hold_en = 1;
      t0 = cyc;
      @(negedge clk);
      while (!sample_vld_o) @(negedge clk);
      // R6: first window silent, first strobe only after second window
      check("R6 first strobe late", int'((cyc - t0) > N + 1), 1);
      repeat (N / 2) @(negedge clk);
      mon_en = 1; gap_en = 1;
      // R3/R8: load offset of mid-scale, then negative full scale
      run_phase(0, 1, 3, 1'b0, 1'b1, 1500, "R3/R8 zeros");
      // R2/R4/R10: positive full scale, long enough to wrap the counter
      run_phase(1, 1, 24, 1'b0, 1'b0, 0, "R2/R4/R10 ones");
      run_phase(1, 2, 3, 1'b0, 1'b0, 0, "R2/R3 half");
      run_phase(1, 4, 3, 1'b0, 1'b0, 0, "R2/R3 quarter");
      // R9: learn offset
      run_phase(1, 3, 4, 1'b1, 1'b0, 0, "R9 calibrate");
      // R8: software load
      run_phase(2, 3, 3, 1'b0, 1'b1, 0, "R8 write zero");
      cnt_pulse_i = 1'b0; dir_level_i = 1'b0;
      repeat (N + N / 2) @(negedge clk);
      // R5: interval zero idles
      gap_en = 0;
      interval_i = '0;
      repeat (3) @(negedge clk);
      vld_cnt = 0;
      repeat (3 * N) @(negedge clk);
      check("R5 idle strobes", vld_cnt, 0);
      check("R5 strobe spacing errors", gap_err, 0);
      check("R7 hold errors", hold_err, 0);
      check("R2 unconsumed expectations", exp_q.size(), 0);
      finish_run();
   end
endmodule